// File: doc/BRIEF.md
# Banked Operand Collector

This block stands between the warp issue stage and the execution units of a throughput processor. An issued instruction arrives with its warp number, a short operation tag and two source register numbers. It is parked in one of several collector units, which fetch its two source values from a register file made of single-ported banks. When both values are in, the unit hands the instruction and its two operand words to the execution side and frees itself for the next instruction.

Each bank serves one access per cycle. Every cycle a per-bank arbiter looks at all operands still missing across all busy units and picks at most one read for each bank. Independent instructions therefore share the bank ports, and one instruction's reads never block another's on a different bank. Result writeback from the execution side uses the same bank ports and goes ahead of any read. The bank that holds a register depends on both the register number and the warp number, so the same instruction in two warps reads from different banks.

Top module: `oc_operand_collector`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: Register `r` of warp `w` lives in bank `(r + w) mod 4` of a 4-bank register file; a bank performs at most one access (read or write) per cycle.
- R3: An instruction whose two sources fall in different banks, with no competing access, is on `out_valid` in the cycle that follows the second rising edge counted from the edge that accepted it (latency 1 in the bench's edge count).
- R4: When both sources of one instruction map to the same bank, the reads take two cycles and dispatch comes one cycle later than in R3 (latency 2).
- R5: The same register numbers read by two warps in overlapping cycles do not contend, because the warp number shifts the bank.
- R6: When several units want the same bank in one cycle, the unit that was allocated earliest gets it.
- R7: A writeback (`wb_valid`) is always performed in its cycle; it blocks any read of its bank in that cycle, and a later read of the written register returns the new word.
- R8: Each dispatch carries the warp, the operation tag and the register-file contents of its two sources (`out_src0_data` for `in_src0`, `out_src1_data` for `in_src1`); every accepted instruction is dispatched exactly once.
- R9: There are 4 collector units; `in_ready` is 0 while all are busy. A unit that dispatches is free from the next cycle, so `in_ready` rises in the cycle after a dispatch from a full block.
- R10: When more than one unit has all its operands, the earliest-allocated one is dispatched first; one instruction leaves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | A collector unit is free; offer is taken at the edge when both are 1 |
| in_warp | input | 2 | Warp number of the offered instruction |
| in_op | input | 8 | Operation tag carried through to dispatch |
| in_src0 | input | 3 | First source register number |
| in_src1 | input | 3 | Second source register number |
| wb_valid | input | 1 | Writeback request this cycle |
| wb_warp | input | 2 | Warp of the register written back |
| wb_reg | input | 3 | Register number written back |
| wb_data | input | 32 | Word written back |
| out_valid | output | 1 | An instruction with both operands is dispatched this cycle |
| out_warp | output | 2 | Warp of the dispatched instruction |
| out_op | output | 8 | Operation tag of the dispatched instruction |
| out_src0_data | output | 32 | Value of the first source |
| out_src1_data | output | 32 | Value of the second source |

## Verification
The collector is driven with source pairs in separate banks, pairs in one bank, identical register pairs from two warps, overlapping instructions contending for a bank, and writebacks landing on a bank that a pending read needs. Each pattern has an exact dispatch latency that changes if a single rule is broken: a same-bank pair separates a one-read-per-bank arbiter from one that reads both, the two-warp pair separates a warp-shifted bank mapping from a plain one, and the contention cases separate oldest-first from younger-first both at the bank and at dispatch. A full-occupancy run held back by writebacks checks the busy limit, the free-next-cycle rule and the oldest-first order over four queued instructions, while mixed traffic compares every operand word against a bench-side copy of the register file.

// File: rtl/oc_pkg.sv
package oc_pkg;
  parameter int NUM_WARPS     = 4;
  parameter int REGS_PER_WARP = 8;
  parameter int NUM_BANKS     = 4;
  parameter int NUM_CU        = 4;
  parameter int NUM_SRC       = 2;
  parameter int DATA_W        = 32;
  parameter int OP_W          = 8;

  localparam int WARP_W        = $clog2(NUM_WARPS);
  localparam int REG_W         = $clog2(REGS_PER_WARP);
  localparam int BANK_W        = $clog2(NUM_BANKS);
  localparam int ROWS_PER_WARP = REGS_PER_WARP / NUM_BANKS;
  localparam int ROWS          = NUM_WARPS * ROWS_PER_WARP;
  localparam int ROW_W         = $clog2(ROWS);
  localparam int CU_W          = $clog2(NUM_CU);
  localparam int SRC_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // older[i][j] = 1 when unit i was allocated before unit j
  typedef logic [NUM_CU-1:0][NUM_CU-1:0] age_mtx_t;

  // Bank holding a register: register number shifted by the warp number
  function automatic logic [BANK_W-1:0] bank_of(input logic [WARP_W-1:0] w,
                                                input logic [REG_W-1:0]  r);
    return BANK_W'((int'(r) + int'(w)) % NUM_BANKS);
  endfunction

  // Row inside the bank: one stripe of rows per warp
  function automatic logic [ROW_W-1:0] row_of(input logic [WARP_W-1:0] w,
                                              input logic [REG_W-1:0]  r);
    return ROW_W'(int'(w) * ROWS_PER_WARP + int'(r) / NUM_BANKS);
  endfunction

  // Earliest-allocated candidate: {found, index}
  function automatic logic [CU_W:0] oldest_of(input logic [NUM_CU-1:0] cand,
                                              input age_mtx_t          older);
    logic [CU_W:0] res;
    logic          win;
    res = '0;
    for (int i = 0; i < NUM_CU; i++) begin
      win = cand[i];
      for (int j = 0; j < NUM_CU; j++)
        if (j != i && cand[j] && !older[i][j]) win = 1'b0;
      if (win) res = {1'b1, CU_W'(i)};
    end
    return res;
  endfunction
endpackage

// File: rtl/oc_bank_rf.sv
module oc_bank_rf
  import oc_pkg::*;
(
  input  logic                               clk,
  input  logic                               wr_en,
  input  logic [BANK_W-1:0]                  wr_bank,
  input  logic [ROW_W-1:0]                   wr_row,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]    rd_row,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]   rd_data
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == BANK_W'(b)) mem[wr_row] <= wr_data;
    end
    assign rd_data[b] = mem[rd_row[b]];
  end
endmodule

// File: rtl/oc_bank_arbiter.sv
module oc_bank_arbiter
  import oc_pkg::*;
(
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [NUM_CU-1:0][NUM_SRC-1:0]              req_vld,
  input  logic [NUM_CU-1:0][NUM_SRC-1:0][BANK_W-1:0]  req_bank,
  input  age_mtx_t                                    older,
  input  logic                                        wb_en,
  input  logic [BANK_W-1:0]                           wb_bank,
  output logic [NUM_CU-1:0][NUM_SRC-1:0]              gnt,
  output logic [NUM_BANKS-1:0]                        bank_rd_en,
  output logic [NUM_BANKS-1:0][CU_W-1:0]              bank_cu,
  output logic [NUM_BANKS-1:0][SRC_W-1:0]             bank_src
);
  always_comb begin
    logic [NUM_CU-1:0] cand;
    logic [CU_W:0]     pick;
    logic [SRC_W-1:0]  sel;
    gnt        = '0;
    bank_rd_en = '0;
    bank_cu    = '0;
    bank_src   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      cand = '0;
      for (int i = 0; i < NUM_CU; i++)
        for (int s = 0; s < NUM_SRC; s++)
          if (req_vld[i][s] && req_bank[i][s] == BANK_W'(b)) cand[i] = 1'b1;
      pick = oldest_of(cand, older);
      sel  = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--)
        if (req_vld[pick[CU_W-1:0]][s] && req_bank[pick[CU_W-1:0]][s] == BANK_W'(b))
          sel = SRC_W'(s);
      // a writeback owns the bank port for the cycle
      if (pick[CU_W] && !(wb_en && wb_bank == BANK_W'(b))) begin
        bank_rd_en[b]                  = 1'b1;
        bank_cu[b]                     = pick[CU_W-1:0];
        bank_src[b]                    = sel;
        gnt[pick[CU_W-1:0]][sel]       = 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    logic [NUM_CU*NUM_SRC-1:0] hit;
    for (genvar i = 0; i < NUM_CU; i++) begin : g_cu
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign hit[i*NUM_SRC+s] = gnt[i][s] && req_bank[i][s] == BANK_W'(b);
      end
    end
    p_one_read_per_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
    p_wb_owns_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && wb_bank == BANK_W'(b)) |-> (hit == '0));
  end
endmodule

// File: rtl/oc_collector_unit.sv
module oc_collector_unit
  import oc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              alloc,
  input  logic [WARP_W-1:0]                 a_warp,
  input  logic [OP_W-1:0]                   a_op,
  input  logic [NUM_SRC-1:0][REG_W-1:0]     a_src,
  input  logic [NUM_SRC-1:0]                gnt,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]    gnt_data,
  input  logic                              drop,
  output logic                              busy,
  output logic [WARP_W-1:0]                 warp,
  output logic [OP_W-1:0]                   op,
  output logic [NUM_SRC-1:0][REG_W-1:0]     src,
  output logic [NUM_SRC-1:0]                pend,
  output logic                              done,
  output logic [NUM_SRC-1:0][DATA_W-1:0]    data
);
  logic [NUM_SRC-1:0] rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rdy  <= '0;
      warp <= '0;
      op   <= '0;
      src  <= '0;
      data <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      rdy  <= '0;
      warp <= a_warp;
      op   <= a_op;
      src  <= a_src;
    end else begin
      if (drop) busy <= 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (gnt[s]) begin
          data[s] <= gnt_data[s];
          rdy[s]  <= 1'b1;
        end
    end
  end

  assign pend = {NUM_SRC{busy}} & ~rdy;
  assign done = busy && (&rdy);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    p_grant_to_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[s] |-> (busy && !rdy[s]));
  end
  p_drop_only_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> done);
  p_no_alloc_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy);
endmodule

// File: rtl/oc_operand_collector.sv
module oc_operand_collector
  import oc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WARP_W-1:0]   in_warp,
  input  logic [OP_W-1:0]     in_op,
  input  logic [REG_W-1:0]    in_src0,
  input  logic [REG_W-1:0]    in_src1,
  input  logic                wb_valid,
  input  logic [WARP_W-1:0]   wb_warp,
  input  logic [REG_W-1:0]    wb_reg,
  input  logic [DATA_W-1:0]   wb_data,
  output logic                out_valid,
  output logic [WARP_W-1:0]   out_warp,
  output logic [OP_W-1:0]     out_op,
  output logic [DATA_W-1:0]   out_src0_data,
  output logic [DATA_W-1:0]   out_src1_data
);
  // unit state
  logic [NUM_CU-1:0]                         cu_busy, cu_done, cu_alloc, cu_drop;
  logic [NUM_CU-1:0][WARP_W-1:0]             cu_warp;
  logic [NUM_CU-1:0][OP_W-1:0]               cu_op;
  logic [NUM_CU-1:0][NUM_SRC-1:0][REG_W-1:0] cu_src;
  logic [NUM_CU-1:0][NUM_SRC-1:0]            cu_pend;
  logic [NUM_CU-1:0][NUM_SRC-1:0][DATA_W-1:0] cu_data;
  // arbitration and bank traffic
  logic [NUM_CU-1:0][NUM_SRC-1:0][BANK_W-1:0] req_bank;
  logic [NUM_CU-1:0][NUM_SRC-1:0]             gnt;
  logic [NUM_CU-1:0][NUM_SRC-1:0][DATA_W-1:0] gnt_data;
  logic [NUM_BANKS-1:0]                       bank_rd_en;
  logic [NUM_BANKS-1:0][CU_W-1:0]             bank_cu;
  logic [NUM_BANKS-1:0][SRC_W-1:0]            bank_src;
  logic [NUM_BANKS-1:0][ROW_W-1:0]            rd_row;
  logic [NUM_BANKS-1:0][DATA_W-1:0]           rd_data;
  logic [BANK_W-1:0]                          wb_bank;
  logic [ROW_W-1:0]                           wb_row;
  // allocation, age and dispatch
  age_mtx_t          older;
  logic [CU_W-1:0]   alloc_idx;
  logic              alloc_fire;
  logic [CU_W:0]     disp_pick;
  logic [CU_W-1:0]   disp_idx;

  // free unit search: lowest index
  always_comb begin
    alloc_idx = '0;
    in_ready  = 1'b0;
    for (int i = NUM_CU - 1; i >= 0; i--)
      if (!cu_busy[i]) begin
        alloc_idx = CU_W'(i);
        in_ready  = 1'b1;
      end
  end
  assign alloc_fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) older <= '0;
    else if (alloc_fire)
      for (int j = 0; j < NUM_CU; j++)
        if (CU_W'(j) != alloc_idx) begin
          older[j][alloc_idx] <= 1'b1;
          older[alloc_idx][j] <= 1'b0;
        end
  end

  assign disp_pick = oldest_of(cu_done, older);
  assign disp_idx  = disp_pick[CU_W-1:0];
  assign out_valid = disp_pick[CU_W];

  for (genvar g = 0; g < NUM_CU; g++) begin : g_cu
    assign cu_alloc[g] = alloc_fire && alloc_idx == CU_W'(g);
    assign cu_drop[g]  = out_valid && disp_idx == CU_W'(g);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign req_bank[g][s] = bank_of(cu_warp[g], cu_src[g][s]);
      assign gnt_data[g][s] = rd_data[req_bank[g][s]];
    end
    oc_collector_unit u_cu (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (cu_alloc[g]),
      .a_warp   (in_warp),
      .a_op     (in_op),
      .a_src    ({in_src1, in_src0}),
      .gnt      (gnt[g]),
      .gnt_data (gnt_data[g]),
      .drop     (cu_drop[g]),
      .busy     (cu_busy[g]),
      .warp     (cu_warp[g]),
      .op       (cu_op[g]),
      .src      (cu_src[g]),
      .pend     (cu_pend[g]),
      .done     (cu_done[g]),
      .data     (cu_data[g])
    );
  end

  oc_bank_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (cu_pend),
    .req_bank   (req_bank),
    .older      (older),
    .wb_en      (wb_valid),
    .wb_bank    (wb_bank),
    .gnt        (gnt),
    .bank_rd_en (bank_rd_en),
    .bank_cu    (bank_cu),
    .bank_src   (bank_src)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
    assign rd_row[b] = row_of(cu_warp[bank_cu[b]], cu_src[bank_cu[b]][bank_src[b]]);
  end

  assign wb_bank = bank_of(wb_warp, wb_reg);
  assign wb_row  = row_of(wb_warp, wb_reg);

  oc_bank_rf u_rf (
    .clk     (clk),
    .wr_en   (wb_valid),
    .wr_bank (wb_bank),
    .wr_row  (wb_row),
    .wr_data (wb_data),
    .rd_row  (rd_row),
    .rd_data (rd_data)
  );

  assign out_warp      = cu_warp[disp_idx];
  assign out_op        = cu_op[disp_idx];
  assign out_src0_data = cu_data[disp_idx][0];
  assign out_src1_data = cu_data[disp_idx][1];

  p_wb_blocks_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !bank_rd_en[wb_bank]);
  p_free_after_dispatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_ready) |=> in_ready);
  p_full_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&cu_busy) |-> !in_ready);
endmodule

// File: tb/oc_operand_collector_tb_top.sv
`timescale 1ns/1ps
module oc_operand_collector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_warp = '0;
  logic [7:0]  in_op = '0;
  logic [2:0]  in_src0 = '0, in_src1 = '0;
  logic        wb_valid = 1'b0;
  logic [1:0]  wb_warp = '0;
  logic [2:0]  wb_reg = '0;
  logic [31:0] wb_data = '0;
  logic        out_valid;
  logic [1:0]  out_warp;
  logic [7:0]  out_op;
  logic [31:0] out_src0_data, out_src1_data;

  always #2.5 clk = ~clk;

  oc_operand_collector dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_warp(in_warp), .in_op(in_op), .in_src0(in_src0), .in_src1(in_src1),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .wb_data(wb_data),
    .out_valid(out_valid), .out_warp(out_warp), .out_op(out_op),
    .out_src0_data(out_src0_data), .out_src1_data(out_src1_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [31:0] model [4][8];

  typedef struct {
    logic [7:0]  op;
    logic [1:0]  warp;
    logic [31:0] d0;
    logic [31:0] d1;
    int          acc;
    int          lat;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  logic [7:0] disp_log[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pop the matching expected item and compare
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      int idx;
      idx = -1;
      for (int k = 0; k < exp_q.size(); k++)
        if (exp_q[k].op == out_op) idx = k;
      disp_log.push_back(out_op);
      if (idx < 0) begin
        check(1'b0, "R8", "unexpected dispatch op", out_op, 0);
      end else begin
        exp_t e;
        e = exp_q[idx];
        exp_q.delete(idx);
        check(out_warp == e.warp && out_src0_data == e.d0 && out_src1_data == e.d1,
              "R8", $sformatf("op %0d warp/src0 data", e.op),
              {out_warp, out_src0_data}, {e.warp, e.d0});
        check(out_src1_data == e.d1, "R8", $sformatf("op %0d src1 data", e.op),
              out_src1_data, e.d1);
        if (e.lat >= 0)
          check(cyc - e.acc == e.lat, e.req, $sformatf("op %0d latency", e.op),
                cyc - e.acc, e.lat);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    in_valid = 1'b0;
    wb_valid = 1'b0;
  endtask

  task automatic drive_issue(input logic [1:0] w, input logic [2:0] s0,
                             input logic [2:0] s1, input logic [7:0] op,
                             input int lat, input string req);
    exp_t e;
    check(in_ready == 1'b1, req, "in_ready before issue", in_ready, 1);
    in_valid = 1'b1; in_warp = w; in_src0 = s0; in_src1 = s1; in_op = op;
    e.op = op; e.warp = w; e.d0 = model[w][s0]; e.d1 = model[w][s1];
    e.acc = cyc + 1; e.lat = lat; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drive_wb(input logic [1:0] w, input logic [2:0] r,
                          input logic [31:0] d);
    wb_valid = 1'b1; wb_warp = w; wb_reg = r; wb_data = d;
    model[w][r] = d;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 100) begin
      tick();
      guard++;
    end
    repeat (2) tick();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // load the whole register file through writeback (R7)
    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 8; r++) begin
        drive_wb(2'(w), 3'(r), 32'h5A00_0000 | (w << 12) | (r << 4) | (w ^ r));
        tick();
      end
    tick();

    // R3: sources in banks 1 and 2 of warp 0
    drive_issue(2'd0, 3'd1, 3'd2, 8'd1, 1, "R3"); tick();
    drain();

    // R4: r0 and r4 of warp 0 both in bank 0
    drive_issue(2'd0, 3'd0, 3'd4, 8'd2, 2, "R4"); tick();
    drain();

    // R5: warp 0 uses bank 0 twice, warp 1 the same registers in bank 1
    drive_issue(2'd0, 3'd0, 3'd4, 8'd3, 2, "R5"); tick();
    drive_issue(2'd1, 3'd0, 3'd4, 8'd4, 2, "R5"); tick();
    drain();

    // R6: older unit keeps bank 0, younger waits one cycle
    drive_issue(2'd0, 3'd0, 3'd4, 8'd5, 2, "R6"); tick();
    drive_issue(2'd0, 3'd0, 3'd1, 8'd6, 2, "R6"); tick();
    drain();

    // R10: both complete together, older leaves first
    drive_issue(2'd0, 3'd0, 3'd4, 8'd7, 2, "R10"); tick();
    drive_issue(2'd0, 3'd1, 3'd2, 8'd8, 2, "R10"); tick();
    drain();

    // R7: writeback to bank 0 delays the r0 read by one cycle
    drive_issue(2'd0, 3'd0, 3'd1, 8'd9, 2, "R7"); tick();
    drive_wb(2'd0, 3'd4, 32'hDEAD_0004); tick();
    drain();
    // R7: new word is read back
    drive_issue(2'd0, 3'd4, 3'd5, 8'd10, 1, "R7"); tick();
    drain();

    // R8: mixed traffic over warps 2 and 3 with writebacks between
    for (int k = 0; k < 8; k++) begin
      drive_issue(2'(2 + (k % 2)), 3'((k * 3) % 8), 3'((k * 5 + 1) % 8),
                  8'(40 + k), -1, "R8");
      tick();
      if (k % 3 == 0) begin
        drain();
        drive_wb(2'(2 + (k % 2)), 3'((k * 3) % 8), 32'hC0DE_0000 + k);
        tick();
      end
    end
    drain();

    // R9: fill all units while writebacks hold bank 0
    disp_log.delete();
    for (int k = 0; k < 4; k++) begin
      drive_wb(2'd0, 3'd0, model[0][0]);
      drive_issue(2'd0, 3'd0, 3'd4, 8'(20 + k), -1, "R9");
      tick();
    end
    drive_wb(2'd0, 3'd0, model[0][0]);
    check(in_ready == 1'b0, "R9", "in_ready with all units busy", in_ready, 0);
    tick();
    begin
      int guard;
      guard = 0;
      while (!out_valid && guard < 20) begin
        tick();
        guard++;
      end
    end
    check(out_op == 8'd20, "R6", "first dispatch of full block", out_op, 20);
    check(in_ready == 1'b0, "R9", "in_ready in dispatch cycle", in_ready, 0);
    tick();
    check(in_ready == 1'b1, "R9", "in_ready after dispatch", in_ready, 1);
    drain();
    check(disp_log.size() == 4, "R10", "dispatch count", disp_log.size(), 4);
    for (int k = 0; k < 4 && k < disp_log.size(); k++)
      check(disp_log[k] == 8'(20 + k), "R6", "oldest-first order",
            disp_log[k], 20 + k);

    check(exp_q.size() == 0, "R8", "instructions left undispatched", exp_q.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule